// File: doc/BRIEF.md
# Bus-Takeover Master Sequencer

This block sits on an expansion card and performs single memory or I/O transfers on a Z80 system bus while the CPU is parked. A requester presents an address, write data, a read/write flag and a memory/I/O flag. The block pulls the shared bus-request line low and waits until the CPU's acknowledge has passed a two-flop synchronizer. It then drives the address, the data and the control strobes.

Each access keeps its strobes active for one whole video slot of `VIDEO_CLKS` system clocks, so the video gate array can place the access in the part of its slot that belongs to the CPU. Several back-to-back requests may share one ownership of the bus. The number per ownership is capped at `MAX_BURST`, so the CPU gets the bus back often enough to keep dynamic RAM refreshed.

When the bus is handed back, the strobes go inactive first. One clock later the drivers float, and one clock after that the request line is released. The block then waits until it sees the acknowledge go inactive before it accepts new work.

Top module: `busTakeoverMaster`

## Requirements
- R1: After reset, `busReqLow` is 0. The clock edge that accepts a request from idle (`reqValid` and `reqReady` both 1) raises `busReqLow` and `busy`, and both are high in the cycle that follows. `busReqLow`=1 means "pull the open-drain line low", and the block never drives the line high.
- R2: `addrOe` and `ctlOe` rise only after `busAckN` has been low at two or more earlier clock edges in a row.
- R3: `addrOe`, `ctlOe` or `dataOe` may be 1 only while `busReqLow`=1 and `busAckN`=0. `dataOe` is never 1 while `rdN` is low.
- R4: During a strobe window exactly one of `mreqN`/`iorqN` is low: `mreqN` when `reqMem`=1 and `iorqN` when `reqMem`=0. Exactly one of `rdN`/`wrN` is low: `wrN` when `reqWrite`=1 and `rdN` when `reqWrite`=0.
- R5: `m1N` is never low while `iorqN` is low.
- R6: For each transfer the strobes stay active for exactly `VIDEO_CLKS` consecutive clocks, and `addrOut` stays constant throughout that window.
- R7: On release, a cycle with the drivers enabled and the strobes inactive comes first. Next comes one cycle with the drivers disabled and `busReqLow` still 1. `busReqLow` falls only after that.
- R8: A request offered in the one-clock gap after a transfer continues the same ownership, up to `MAX_BURST` transfers. Any transfer beyond that starts a new ownership.
- R9: `done` pulses for exactly one clock, in the cycle right after the last strobe cycle of every transfer. For a read, `rdData` in that cycle holds the value on `dataIn` during the final strobe clock.
- R10: `busy` is high from acceptance until the synchronized acknowledge is seen inactive, and it is high whenever `busAckN` is low. `reqReady` is 1 only in idle, or in the post-transfer gap while burst room remains.
- R11: When `busy` is 0, `busReqLow` and `ctlOe` are both 0. Every accepted transfer produces exactly one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Transfer request present |
| reqAddr | input | ADDR_W | Transfer address |
| reqData | input | DATA_W | Write data |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqMem | input | 1 | 1 = memory space, 0 = I/O space |
| reqReady | output | 1 | Request accepted at this edge when reqValid is 1 |
| busy | output | 1 | Transfer or ownership in progress |
| done | output | 1 | One-clock completion pulse |
| rdData | output | DATA_W | Read result, valid with done |
| busReqLow | output | 1 | 1 = pull bus-request line low; 0 = float |
| busAckN | input | 1 | CPU bus acknowledge, active low, asynchronous |
| addrOut | output | ADDR_W | Address to bus |
| addrOe | output | 1 | Address driver enable |
| dataOut | output | DATA_W | Write data to bus |
| dataIn | input | DATA_W | Data from bus |
| dataOe | output | 1 | Data driver enable |
| ctlOe | output | 1 | Control strobe driver enable |
| mreqN | output | 1 | Memory request strobe, active low |
| iorqN | output | 1 | I/O request strobe, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| m1N | output | 1 | Opcode-fetch marker, held inactive |

## Verification
Two things can happen in the same clock during a burst. The `done` pulse of one transfer falls in the gap cycle, and in that same cycle the next request can be accepted, which loads a new address. Back-to-back requests from the stimulus provoke this, and so does a directed run of `MAX_BURST`+2 writes. The bench checks the read result in the `done` cycle against its own model of memory and I/O. It also checks that the new address appears only after the strobes have gone inactive. Finally, it checks that the burst count per ownership splits as `MAX_BURST` followed by the remainder.

// File: rtl/takeoverPkg.sv
package takeoverPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_GRANT,
    ST_SETUP,
    ST_HOLD,
    ST_GAP,
    ST_RELEASE,
    ST_FREE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch request fields
    logic drive;    // bus drivers enabled
    logic strobe;   // access strobes active
    logic capture;  // sample read data
  } busCtl_t;

endpackage

// File: rtl/takeoverSync.sv
module takeoverSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else       shiftReg <= {shiftReg[STAGES-2:0], din};
  end

  assign dout = shiftReg[STAGES-1];
endmodule

// File: rtl/takeoverCtrl.sv
module takeoverCtrl
  import takeoverPkg::*;
#(
  parameter int VIDEO_CLKS = 16,
  parameter int MAX_BURST  = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    grantSync,
  output busCtl_t ctl,
  output logic    busReqLow,
  output logic    busy,
  output logic    reqReady,
  output logic    done
);
  localparam int HOLD_W  = $clog2(VIDEO_CLKS + 1);
  localparam int BURST_W = $clog2(MAX_BURST + 1);

  seqState_t state, nextState;
  logic [HOLD_W-1:0]  holdCnt;
  logic [BURST_W-1:0] burstCnt;
  logic holdLast, burstRoom, accept;

  assign holdLast  = (holdCnt == '0);
  assign burstRoom = (burstCnt < BURST_W'(MAX_BURST));

  always_comb begin
    reqReady = (state == ST_IDLE) || ((state == ST_GAP) && burstRoom);
    accept   = reqReady && reqValid;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:       if (accept) nextState = ST_WAIT_GRANT;
      ST_WAIT_GRANT: if (grantSync) nextState = ST_SETUP;
      ST_SETUP:      nextState = ST_HOLD;
      ST_HOLD:       if (holdLast) nextState = ST_GAP;
      ST_GAP:        nextState = accept ? ST_SETUP : ST_RELEASE;
      ST_RELEASE:    nextState = ST_FREE;
      ST_FREE:       if (!grantSync) nextState = ST_IDLE;
      default:       nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.load    = accept;
    ctl.drive   = (state == ST_SETUP) || (state == ST_HOLD) || (state == ST_GAP);
    ctl.strobe  = (state == ST_HOLD);
    ctl.capture = (state == ST_HOLD) && holdLast;
  end

  assign busReqLow = (state != ST_IDLE) && (state != ST_FREE);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      holdCnt  <= '0;
      burstCnt <= '0;
      done     <= 1'b0;
    end else begin
      state <= nextState;
      done  <= ctl.capture;
      if (state == ST_SETUP)
        holdCnt <= HOLD_W'(VIDEO_CLKS - 1);
      else if (state == ST_HOLD && !holdLast)
        holdCnt <= holdCnt - 1'b1;
      if (accept)
        burstCnt <= (state == ST_IDLE) ? BURST_W'(1) : burstCnt + 1'b1;
    end
  end
endmodule

// File: rtl/takeoverDatapath.sv
module takeoverDatapath
  import takeoverPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              reqWrite,
  input  logic              reqMem,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              addrOe,
  output logic              dataOe,
  output logic              ctlOe,
  output logic              mreqN,
  output logic              iorqN,
  output logic              rdN,
  output logic              wrN,
  output logic [DATA_W-1:0] rdData
);
  logic writeReg, memReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrOut  <= '0;
      dataOut  <= '0;
      writeReg <= 1'b0;
      memReg   <= 1'b0;
      rdData   <= '0;
    end else begin
      if (ctl.load) begin
        addrOut  <= reqAddr;
        dataOut  <= reqData;
        writeReg <= reqWrite;
        memReg   <= reqMem;
      end
      if (ctl.capture && !writeReg)
        rdData <= dataIn;
    end
  end

  always_comb begin
    addrOe = ctl.drive;
    ctlOe  = ctl.drive;
    dataOe = ctl.drive && writeReg;
    mreqN  = !(ctl.strobe && memReg);
    iorqN  = !(ctl.strobe && !memReg);
    rdN    = !(ctl.strobe && !writeReg);
    wrN    = !(ctl.strobe && writeReg);
  end
endmodule

// File: rtl/busTakeoverMaster.sv
module busTakeoverMaster
  import takeoverPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int VIDEO_CLKS = 16,
  parameter int MAX_BURST  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              reqWrite,
  input  logic              reqMem,
  output logic              reqReady,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              busReqLow,
  input  logic              busAckN,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic [DATA_W-1:0] dataOut,
  input  logic [DATA_W-1:0] dataIn,
  output logic              dataOe,
  output logic              ctlOe,
  output logic              mreqN,
  output logic              iorqN,
  output logic              rdN,
  output logic              wrN,
  output logic              m1N
);
  busCtl_t ctl;
  logic grantSync;

  takeoverSync #(.STAGES(2)) uSync (
    .clk(clk), .rstN(rstN), .din(!busAckN), .dout(grantSync)
  );

  takeoverCtrl #(.VIDEO_CLKS(VIDEO_CLKS), .MAX_BURST(MAX_BURST)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .grantSync(grantSync),
    .ctl(ctl), .busReqLow(busReqLow), .busy(busy), .reqReady(reqReady),
    .done(done)
  );

  takeoverDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqAddr(reqAddr), .reqData(reqData), .reqWrite(reqWrite), .reqMem(reqMem),
    .dataIn(dataIn), .addrOut(addrOut), .dataOut(dataOut),
    .addrOe(addrOe), .dataOe(dataOe), .ctlOe(ctlOe),
    .mreqN(mreqN), .iorqN(iorqN), .rdN(rdN), .wrN(wrN), .rdData(rdData)
  );

  // opcode-fetch marker is never driven active by this master
  assign m1N = 1'b1;
endmodule

// File: rtl/takeoverChecker.sv
module takeoverChecker (
  input logic clk,
  input logic rstN,
  input logic busReqLow,
  input logic busAckN,
  input logic busy,
  input logic done,
  input logic addrOe,
  input logic dataOe,
  input logic ctlOe,
  input logic mreqN,
  input logic iorqN,
  input logic rdN
);
  p_grant_seen_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlOe) |-> (!busAckN && $past(!busAckN)));

  p_drive_owned_r3: assert property (@(posedge clk) disable iff (!rstN)
    (addrOe || ctlOe || dataOe) |-> (busReqLow && !busAckN));

  p_no_read_contention_r3: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !dataOe);

  p_space_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(!mreqN && !iorqN));

  p_strobes_before_float_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctlOe) |-> $past(mreqN && iorqN));

  p_float_before_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReqLow) |-> (!ctlOe && !$past(ctlOe)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_busy_while_granted_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busAckN |-> busy);
endmodule

bind busTakeoverMaster takeoverChecker uChk (
  .clk(clk), .rstN(rstN), .busReqLow(busReqLow), .busAckN(busAckN),
  .busy(busy), .done(done), .addrOe(addrOe), .dataOe(dataOe), .ctlOe(ctlOe),
  .mreqN(mreqN), .iorqN(iorqN), .rdN(rdN)
);

// File: tb/busTakeoverMaster_test.sv
module busTakeoverMaster_test;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int VCLK   = 16;
  localparam int MAXB   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic reqWrite = 1'b0, reqMem = 1'b0;
  logic reqReady, busy, done, busReqLow, addrOe, dataOe, ctlOe;
  logic mreqN, iorqN, rdN, wrN, m1N;
  logic busAckN = 1'b1;
  logic [DATA_W-1:0] rdData, dataOut, dataIn;
  logic [ADDR_W-1:0] addrOut;

  int checks = 0, fails = 0;

  busTakeoverMaster #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VIDEO_CLKS(VCLK),
                      .MAX_BURST(MAXB)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqData(reqData), .reqWrite(reqWrite), .reqMem(reqMem),
    .reqReady(reqReady), .busy(busy), .done(done), .rdData(rdData),
    .busReqLow(busReqLow), .busAckN(busAckN), .addrOut(addrOut),
    .addrOe(addrOe), .dataOut(dataOut), .dataIn(dataIn), .dataOe(dataOe),
    .ctlOe(ctlOe), .mreqN(mreqN), .iorqN(iorqN), .rdN(rdN), .wrN(wrN),
    .m1N(m1N)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // device models (the bus side) and the bench's expected view
  logic [DATA_W-1:0] devMem [16];
  logic [DATA_W-1:0] devIo  [16];
  logic [DATA_W-1:0] expMem [16];
  logic [DATA_W-1:0] expIo  [16];

  assign dataIn = (ctlOe && !rdN) ? (!mreqN ? devMem[addrOut[3:0]] : devIo[addrOut[3:0]])
                                  : 8'hEE;

  always @(negedge clk) begin
    if (ctlOe && !wrN) begin
      if (!mreqN) devMem[addrOut[3:0]] <= dataOut;
      if (!iorqN) devIo[addrOut[3:0]]  <= dataOut;
    end
  end

  // CPU side: grant after a delay, release ack after request drops
  initial begin
    forever begin
      @(posedge clk); #2;
      if (busReqLow && busAckN) begin
        repeat ($urandom_range(0, 4)) @(posedge clk);
        #2 busAckN = 1'b0;
      end else if (!busReqLow && !busAckN) begin
        repeat ($urandom_range(0, 3)) @(posedge clk);
        #2 busAckN = 1'b1;
      end
    end
  end

  // expected completion queue
  bit          qRead [64];
  logic [7:0]  qVal  [64];
  int wp = 0, rp = 0;

  // port-level monitor
  bit prevOe = 0, prev2Oe = 0, prevStrobe = 0, prev2Strobe = 0, prevReq = 0;
  int ackLowRun = 0, runLen = 0, ownXfers = 0, ownIdx = 0;
  int ownLog [64];
  logic [ADDR_W-1:0] runAddr = '0;
  bit runBad = 0;

  always @(negedge clk) begin
    if (rstN) begin
      automatic bit strobe = ctlOe && (!mreqN || !iorqN);
      if (!iorqN) check(m1N == 1'b1, "R5", "m1N with iorqN low", m1N, 1);
      if (strobe) begin
        check((mreqN ^ iorqN) && (rdN ^ wrN), "R4", "one space and one direction",
              {mreqN, iorqN, rdN, wrN}, 0);
      end
      if (addrOe || ctlOe || dataOe)
        check(busReqLow && !busAckN, "R3", "drivers only while owned",
              {busReqLow, busAckN}, 2);
      if (ctlOe && !rdN) check(!dataOe, "R3", "no data drive on read", dataOe, 0);
      if (ctlOe && !prevOe)
        check(ackLowRun >= 2, "R2", "ack low edges before drive", ackLowRun, 2);
      ackLowRun = busAckN ? 0 : ackLowRun + 1;
      if (strobe) begin
        if (!prevStrobe) begin runLen = 0; runAddr = addrOut; runBad = 0; ownXfers++; end
        runLen++;
        if (addrOut != runAddr) runBad = 1;
      end else if (prevStrobe) begin
        check(runLen == VCLK, "R6", "strobe window length", runLen, VCLK);
        check(!runBad, "R6", "address stable in window", runBad, 0);
      end
      if (prevReq && !busReqLow) begin
        check(!prevOe && prev2Oe && !prev2Strobe, "R7", "release order",
              {prev2Strobe, prev2Oe, prevOe}, 2);
        check(ownXfers >= 1 && ownXfers <= MAXB, "R8", "transfers per ownership",
              ownXfers, MAXB);
        ownLog[ownIdx % 64] = ownXfers;
        ownIdx++;
        ownXfers = 0;
      end
      if (!busAckN) check(busy, "R10", "busy while ack low", busy, 1);
      if (!busy) check(!busReqLow && !ctlOe, "R11", "quiet when not busy",
                       {busReqLow, ctlOe}, 0);
      if (done) begin
        check(prevStrobe && !strobe, "R9", "done right after window",
              {prevStrobe, strobe}, 2);
        check(wp != rp, "R11", "done matches a transfer", wp - rp, 1);
        if (wp != rp) begin
          if (qRead[rp % 64])
            check(rdData == qVal[rp % 64], "R9", "read data", rdData, qVal[rp % 64]);
          rp++;
        end
      end
      prev2Oe = prevOe; prev2Strobe = prevStrobe;
      prevOe = ctlOe; prevStrobe = strobe; prevReq = busReqLow;
    end
  end

  // request one transfer; returns at the negedge after acceptance
  task automatic issue(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                       input bit wr, input bit mem);
    bit fromIdle;
    reqAddr = a; reqData = d; reqWrite = wr; reqMem = mem; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    fromIdle = !busy;
    @(posedge clk);
    qRead[wp % 64] = !wr;
    qVal[wp % 64]  = mem ? expMem[a[3:0]] : expIo[a[3:0]];
    wp++;
    if (wr) begin
      if (mem) expMem[a[3:0]] = d; else expIo[a[3:0]] = d;
    end
    @(negedge clk);
    reqValid = 1'b0;
    if (fromIdle) begin
      check(busReqLow && busy, "R1", "request line after accept",
            {busReqLow, busy}, 3);
      check(!reqReady, "R10", "not ready while waiting for grant", reqReady, 0);
    end
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    int startIdx;
    void'($urandom(32'd20240317));
    for (int i = 0; i < 16; i++) begin
      devMem[i] = 8'(i * 17 + 3); expMem[i] = 8'(i * 17 + 3);
      devIo[i]  = 8'(i * 29 + 5); expIo[i]  = 8'(i * 29 + 5);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!busReqLow && !busy && !done && !ctlOe && !addrOe && !dataOe, "R11",
          "reset outputs", {busReqLow, busy, done, ctlOe}, 0);
    check(reqReady, "R10", "ready after reset", reqReady, 1);
    check(busReqLow == 1'b0, "R1", "request line floats after reset", busReqLow, 0);

    // directed: memory write, I/O write, read back both
    issue(16'h1234, 8'hA5, 1'b1, 1'b1); waitIdle();
    issue(16'h0035, 8'h5A, 1'b1, 1'b0); waitIdle();
    issue(16'h1234, 8'h00, 1'b0, 1'b1); waitIdle();
    issue(16'h0035, 8'h00, 1'b0, 1'b0); waitIdle();

    // directed: back-to-back burst beyond the limit (R8)
    startIdx = ownIdx;
    for (int i = 0; i < MAXB + 2; i++)
      issue(16'(16'h4000 + i), 8'(8'h80 + i), i[0], 1'b1);
    waitIdle();
    check(ownIdx - startIdx == 2, "R8", "ownerships for long burst", ownIdx - startIdx, 2);
    check(ownLog[startIdx % 64] == MAXB, "R8", "first ownership full",
          ownLog[startIdx % 64], MAXB);
    check(ownLog[(startIdx + 1) % 64] == 2, "R8", "second ownership remainder",
          ownLog[(startIdx + 1) % 64], 2);

    // random mix, sometimes back-to-back, sometimes with idle gaps
    for (int i = 0; i < 48; i++) begin
      issue(16'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 2) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
    end
    waitIdle();
    repeat (4) @(negedge clk);
    check(wp == rp, "R11", "every transfer completed", rp, wp);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule